// File: doc/BRIEF.md
# Windowed Local Memory Bridge

This block lets a 32-bit host register bus reach a large on-card SRAM through a small, fixed aperture. The host first programs a window base register. Every word it then reads or writes at an offset inside the aperture goes to the SRAM location formed from the upper bits of the base and the offset inside the window. The base bits that fall inside the window are kept only for read-back and play no part in the SRAM address.

Software copies or clears any word-aligned region this way, one word per access. Each time the region crosses a window edge, software writes the base again. The SRAM itself sits outside the block on a simple synchronous port: a write completes in one cycle, and read data comes back one cycle after the request. A host address whose two low bits are not zero is dropped. Such an access leaves a sticky error flag that software can read in a status word.

The host address has one bit more than the window offset. When that top bit is set, the access goes to the aperture. When it is clear, the access goes to a small register page: word 0 is the window base and word 1 is the status.

Top module: `lmw_bridge`

## Requirements
- R1: While `rst` is high and in the cycle after it, `sram_en` and `host_rvalid` are low. Once reset ends, the window base reads 0 and status bit 0 reads 0.
- R2: A write to register word 0 (host address 0x000) stores all 32 data bits, including the bits below the window size. A later read of that address returns exactly the value written.
- R3: An aligned aperture write (host address bit 11 = 1) drives `sram_en` and `sram_we` high in the next cycle. `sram_addr` is then {base[18:11], host_addr[10:2]} and `sram_wdata` is the host data.
- R4: An aligned aperture read issues an SRAM read at the same word address as R3, with `sram_we` low. The word the SRAM returns appears on `host_rdata`. Base bits [10:0] and [31:19] never affect which SRAM word is addressed.
- R5: Every read, whether to a register or to the aperture, raises `host_rvalid` for exactly one cycle. That cycle is the third rising edge after the request is sampled: the bridge registers the request, the SRAM reads, and the result is captured. Read results come back in request order.
- R6: A request with `host_addr[1:0]` not 0 causes no SRAM access and changes no register. If it is a read, it returns 0 with the usual `host_rvalid` timing. It also sets status bit 0 (register word 1, host address 0x004). The bit stays set until reset.
- R7: Status reads return the error flag in bit 0 and zeros above it. Every other register-page word reads 0, and writes to those words change nothing.
- R8: A base write takes effect for the very next request. A request already accepted keeps the window that was in force when it was sampled, even when the base changes in the following cycle.
- R9: Writes never raise `host_rvalid`. The number of `host_rvalid` pulses equals the number of read requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | One-cycle host access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 12 | Host byte address; bit 11 selects the aperture |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read return data |
| host_rvalid | output | 1 | Read data strobe, one cycle per read |
| sram_en | output | 1 | SRAM access enable |
| sram_we | output | 1 | SRAM write enable |
| sram_addr | output | 17 | SRAM word address |
| sram_wdata | output | 32 | SRAM write data |
| sram_rdata | input | 32 | SRAM read data, valid one cycle after the read |

## Verification
The case that matters is a base update landing in the cycle right next to an aperture access, where the old window and the new one both apply in close succession. The bench provokes it in two ways:
- An aperture read is followed at once by a base write and a second aperture read. The returned words must come from the old window and then from the new one, in that order.
- A base write is followed at once by an aperture write. That word must land in the new window of the SRAM model.

// File: rtl/lmw_pkg.sv
package lmw_pkg;

  // Decoded target of a host access.
  typedef enum logic [1:0] {
    TGT_BASE = 2'd0,
    TGT_STAT = 2'd1,
    TGT_VOID = 2'd2,
    TGT_APER = 2'd3
  } tgt_e;

  // Word indices inside the register page.
  localparam int unsigned IDX_BASE = 0;
  localparam int unsigned IDX_STAT = 1;

  function automatic logic lo_bits_clear(input logic [1:0] lo);
    return lo == 2'b00;
  endfunction

endpackage

// File: rtl/lmw_decode.sv
module lmw_decode
  import lmw_pkg::*;
#(
  parameter int unsigned WIN_LOG2 = 11
) (
  input  logic [WIN_LOG2:0]   host_addr,
  output tgt_e                tgt,
  output logic                aligned,
  output logic [WIN_LOG2-3:0] word_off
);
  localparam int unsigned OFF_W = WIN_LOG2 - 2;

  always_comb begin
    word_off = host_addr[WIN_LOG2-1:2];
    aligned  = lo_bits_clear(host_addr[1:0]);
    if (host_addr[WIN_LOG2])
      tgt = TGT_APER;
    else if (word_off == OFF_W'(IDX_BASE))
      tgt = TGT_BASE;
    else if (word_off == OFF_W'(IDX_STAT))
      tgt = TGT_STAT;
    else
      tgt = TGT_VOID;
  end
endmodule

// File: rtl/lmw_regs.sv
module lmw_regs
  import lmw_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned MEM_LOG2 = 19,
  parameter int unsigned WIN_LOG2 = 11,
  localparam int unsigned PAGE_W  = MEM_LOG2 - WIN_LOG2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              err_set,
  input  tgt_e              rd_tgt,
  output logic [PAGE_W-1:0] page,
  output logic              err_q,
  output logic [DATA_W-1:0] rd_val
);
  logic [DATA_W-1:0] base_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (base_wr) base_q <= wdata;
      if (err_set) err_q  <= 1'b1;
    end
  end

  // Only the bits above the window size pick the SRAM region.
  assign page = base_q[MEM_LOG2-1:WIN_LOG2];

  always_comb begin
    rd_val = '0;
    unique case (rd_tgt)
      TGT_BASE: rd_val = base_q;
      TGT_STAT: rd_val[0] = err_q;
      default:  rd_val = '0;
    endcase
  end

  // R2
  base_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $past(base_wr) |-> base_q == $past(wdata));

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(err_q) || $past(err_set)) |-> err_q);
endmodule

// File: rtl/lmw_sram_port.sv
module lmw_sram_port #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned OFF_W  = 9,
  localparam int unsigned AW    = PAGE_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              wr,
  input  logic [PAGE_W-1:0] page,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] wdata,
  output logic              sram_en,
  output logic              sram_we,
  output logic [AW-1:0]     sram_addr,
  output logic [DATA_W-1:0] sram_wdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sram_en    <= 1'b0;
      sram_we    <= 1'b0;
      sram_addr  <= '0;
      sram_wdata <= '0;
    end else begin
      sram_en <= go;
      sram_we <= go & wr;
      if (go) begin
        sram_addr  <= {page, off};
        sram_wdata <= wdata;
      end
    end
  end

  // R3
  aper_wr_addr_chk: assert property (@(posedge clk) disable iff (rst)
    $past(go && wr) |-> (sram_en && sram_we && sram_addr == {$past(page), $past(off)}
                         && sram_wdata == $past(wdata)));

  // R4
  aper_rd_addr_chk: assert property (@(posedge clk) disable iff (rst)
    $past(go && !wr) |-> (sram_en && !sram_we && sram_addr == {$past(page), $past(off)}));

  // R6
  no_stray_mem_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(go) |-> !sram_en);
endmodule

// File: rtl/lmw_rd_return.sv
module lmw_rd_return #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic              from_mem,
  input  logic [DATA_W-1:0] reg_val,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic              s1_v, s1_mem, s2_v, s2_mem;
  logic [DATA_W-1:0] s1_val, s2_val;

  // Stage 1 matches the SRAM command register, stage 2 the SRAM read cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0; s1_mem <= 1'b0; s1_val <= '0;
      s2_v <= 1'b0; s2_mem <= 1'b0; s2_val <= '0;
      rvalid <= 1'b0; rdata <= '0;
    end else begin
      s1_v   <= issue;
      s1_mem <= from_mem;
      s1_val <= reg_val;
      s2_v   <= s1_v;
      s2_mem <= s1_mem;
      s2_val <= s1_val;
      rvalid <= s2_v;
      if (s2_v) rdata <= s2_mem ? mem_rdata : s2_val;
    end
  end

  // R5
  rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
    $past(issue, 3) |-> rvalid);

  // R9
  no_extra_rvalid_chk: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> $past(issue, 3));
endmodule

// File: rtl/lmw_bridge.sv
module lmw_bridge
  import lmw_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned MEM_LOG2 = 19,
  parameter int unsigned WIN_LOG2 = 11,
  localparam int unsigned HA_W    = WIN_LOG2 + 1,
  localparam int unsigned OFF_W   = WIN_LOG2 - 2,
  localparam int unsigned PAGE_W  = MEM_LOG2 - WIN_LOG2,
  localparam int unsigned SAW     = MEM_LOG2 - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [HA_W-1:0]   host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid,
  output logic              sram_en,
  output logic              sram_we,
  output logic [SAW-1:0]    sram_addr,
  output logic [DATA_W-1:0] sram_wdata,
  input  logic [DATA_W-1:0] sram_rdata
);
  tgt_e              tgt;
  logic              aligned;
  logic [OFF_W-1:0]  word_off;
  logic [PAGE_W-1:0] page;
  logic              err_q;
  logic [DATA_W-1:0] reg_val;
  logic              go, base_wr, err_set, issue, from_mem;

  lmw_decode #(.WIN_LOG2(WIN_LOG2)) u_dec (
    .host_addr (host_addr),
    .tgt       (tgt),
    .aligned   (aligned),
    .word_off  (word_off)
  );

  assign go       = host_req & aligned & (tgt == TGT_APER);
  assign base_wr  = host_req & host_we & aligned & (tgt == TGT_BASE);
  assign err_set  = host_req & ~aligned;
  assign issue    = host_req & ~host_we;
  assign from_mem = aligned & (tgt == TGT_APER);

  lmw_regs #(.DATA_W(DATA_W), .MEM_LOG2(MEM_LOG2), .WIN_LOG2(WIN_LOG2)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .base_wr (base_wr),
    .wdata   (host_wdata),
    .err_set (err_set),
    .rd_tgt  (tgt),
    .page    (page),
    .err_q   (err_q),
    .rd_val  (reg_val)
  );

  lmw_sram_port #(.DATA_W(DATA_W), .PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_port (
    .clk        (clk),
    .rst        (rst),
    .go         (go),
    .wr         (host_we),
    .page       (page),
    .off        (word_off),
    .wdata      (host_wdata),
    .sram_en    (sram_en),
    .sram_we    (sram_we),
    .sram_addr  (sram_addr),
    .sram_wdata (sram_wdata)
  );

  lmw_rd_return #(.DATA_W(DATA_W)) u_ret (
    .clk       (clk),
    .rst       (rst),
    .issue     (issue),
    .from_mem  (from_mem),
    .reg_val   (aligned ? reg_val : '0),
    .mem_rdata (sram_rdata),
    .rdata     (host_rdata),
    .rvalid    (host_rvalid)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!host_rvalid && !sram_en));

  // R6
  misalign_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (host_req && host_addr[1:0] != 2'b00) |=> (!sram_en && err_q));
endmodule

// File: tb/sim_lmw_bridge.sv
`timescale 1ns/1ps
module sim_lmw_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_req = 1'b0, host_we = 1'b0;
  logic [11:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_rvalid;
  logic        sram_en, sram_we;
  logic [16:0] sram_addr;
  logic [31:0] sram_wdata;
  logic [31:0] sram_rdata = '0;

  int checks = 0, fails = 0, rd_cnt = 0, rv_cnt = 0, mem_acc = 0;
  logic [31:0] mem [int];
  logic [31:0] rq [$];

  always #2.5 clk = ~clk;

  lmw_bridge u0 (.*);

  // SRAM model: write in one cycle, registered read data.
  always @(posedge clk) begin
    if (sram_en) begin
      if (sram_we) mem[int'(sram_addr)] = sram_wdata;
      else sram_rdata <= mem.exists(int'(sram_addr)) ? mem[int'(sram_addr)] : 32'h0;
    end
  end

  always @(negedge clk) begin
    if (sram_en) mem_acc++;
    if (host_rvalid) begin rv_cnt++; rq.push_back(host_rdata); end
  end

  function automatic logic [31:0] memval(input int k);
    return mem.exists(k) ? mem[k] : 32'h0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); host_req = 1; host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_req = 0; host_we = 0;
    @(negedge clk);
  endtask

  task automatic do_read(input logic [11:0] a, output logic [31:0] d, output logic lat_ok);
    @(negedge clk); host_req = 1; host_we = 0; host_addr = a; rd_cnt++;
    @(negedge clk); host_req = 0; lat_ok = !host_rvalid;
    @(negedge clk); lat_ok = lat_ok & !host_rvalid;
    @(negedge clk); lat_ok = lat_ok & host_rvalid; d = host_rdata;
  endtask

  typedef struct packed {
    logic        rd;
    logic [11:0] adr;
    logic [31:0] dat;   // write data or expected read data
    logic        mchk;
    logic [16:0] mwa;   // expected SRAM word for writes
    logic [3:0]  rq_id;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 12'h000, 32'h0000_0800, 1'b0, 17'h0,     4'd2}, // R2 base -> window 1
    '{1'b1, 12'h000, 32'h0000_0800, 1'b0, 17'h0,     4'd2}, // R2
    '{1'b0, 12'h804, 32'hA1A1_0001, 1'b1, 17'h00201, 4'd3}, // R3
    '{1'b0, 12'hFFC, 32'hA2A2_0002, 1'b1, 17'h003FF, 4'd3}, // R3 last word of window
    '{1'b0, 12'h000, 32'h0000_0FFF, 1'b0, 17'h0,     4'd2}, // R2 low bits set
    '{1'b1, 12'h000, 32'h0000_0FFF, 1'b0, 17'h0,     4'd2}, // R2
    '{1'b1, 12'h804, 32'hA1A1_0001, 1'b0, 17'h0,     4'd4}, // R4 low base bits ignored
    '{1'b1, 12'hFFC, 32'hA2A2_0002, 1'b0, 17'h0,     4'd4}, // R4
    '{1'b0, 12'h000, 32'h0007_F800, 1'b0, 17'h0,     4'd2}, // top window
    '{1'b0, 12'h800, 32'hA3A3_0003, 1'b1, 17'h1FE00, 4'd3}, // R3
    '{1'b1, 12'h800, 32'hA3A3_0003, 1'b0, 17'h0,     4'd4}, // R4
    '{1'b0, 12'h000, 32'hFFF8_07FF, 1'b0, 17'h0,     4'd2}, // upper bits ignored -> window 0
    '{1'b0, 12'h808, 32'hA4A4_0004, 1'b1, 17'h00002, 4'd3}, // R3
    '{1'b1, 12'h808, 32'hA4A4_0004, 1'b0, 17'h0,     4'd4}, // R4
    '{1'b1, 12'h004, 32'h0000_0000, 1'b0, 17'h0,     4'd7}, // R7 status clear
    '{1'b0, 12'h00C, 32'hDEAD_BEEF, 1'b0, 17'h0,     4'd7}, // R7 unused word write
    '{1'b1, 12'h00C, 32'h0000_0000, 1'b0, 17'h0,     4'd7}, // R7
    '{1'b1, 12'h000, 32'hFFF8_07FF, 1'b0, 17'h0,     4'd7}, // R7 base untouched
    '{1'b1, 12'h404, 32'h0000_0000, 1'b0, 17'h0,     4'd7}  // R7
  };

  initial begin
    repeat (40000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    logic [31:0] d;
    logic ok;
    int acc0;
    repeat (3) @(negedge clk);
    chk("R1 rvalid in reset", {31'b0, host_rvalid}, 32'h0);
    chk("R1 sram_en in reset", {31'b0, sram_en}, 32'h0);
    @(negedge clk); rst = 0;
    do_read(12'h000, d, ok);
    chk("R1 base after reset", d, 32'h0);
    do_read(12'h004, d, ok);
    chk("R1 status after reset", d, 32'h0);
    chk("R5 register read latency", {31'b0, ok}, 32'h1);

    for (int i = 0; i < NV; i++) begin
      if (TBL[i].rd) begin
        do_read(TBL[i].adr, d, ok);
        checks++;
        if (d !== TBL[i].dat || !ok) begin
          fails++;
          $display("FAIL R%0d vec %0d actual=%h/lat%0d expected=%h/lat1",
                   TBL[i].rq_id, i, d, ok, TBL[i].dat);
        end
      end else begin
        do_write(TBL[i].adr, TBL[i].dat);
        if (TBL[i].mchk)
          chk($sformatf("R%0d vec %0d sram word", TBL[i].rq_id, i),
              memval(int'(TBL[i].mwa)), TBL[i].dat);
      end
    end

    // R6 misaligned accesses are dropped
    acc0 = mem_acc;
    do_write(12'h802, 32'h5555_5555);
    chk("R6 no sram access", mem_acc - acc0, 0);
    chk("R6 word untouched", memval(0), 32'h0);
    do_read(12'h805, d, ok);
    chk("R6 misaligned read data", d, 32'h0);
    chk("R6 misaligned read strobe", {31'b0, ok}, 32'h1);
    chk("R6 no sram access on read", mem_acc - acc0, 0);
    do_write(12'h001, 32'h0001_2345);
    do_read(12'h000, d, ok);
    chk("R6 base unchanged", d, 32'hFFF8_07FF);
    do_read(12'h004, d, ok);
    chk("R6 sticky error flag", d, 32'h1);
    do_read(12'h004, d, ok);
    chk("R6 error still set", d, 32'h1);

    // R8 base change next to aperture accesses
    do_write(12'h000, 32'h0000_1000);
    do_write(12'h800, 32'hC0C0_0000);
    do_write(12'h000, 32'h0000_1800);
    do_write(12'h800, 32'hC1C1_0001);
    chk("R8 window 2 word", memval(32'h400), 32'hC0C0_0000);
    rq.delete();
    @(negedge clk); host_req = 1; host_we = 0; host_addr = 12'h800; rd_cnt++;
    @(negedge clk); host_we = 1; host_addr = 12'h000; host_wdata = 32'h0000_1000;
    @(negedge clk); host_we = 0; host_addr = 12'h800; rd_cnt++;
    @(negedge clk); host_req = 0;
    repeat (5) @(negedge clk);
    chk("R5 two results back", rq.size(), 2);
    if (rq.size() == 2) begin
      chk("R8 read before base write uses old window", rq[0], 32'hC1C1_0001);
      chk("R8 read after base write uses new window", rq[1], 32'hC0C0_0000);
    end
    @(negedge clk); host_req = 1; host_we = 1; host_addr = 12'h000; host_wdata = 32'h0000_1800;
    @(negedge clk); host_addr = 12'h804; host_wdata = 32'hC2C2_0002;
    @(negedge clk); host_req = 0; host_we = 0;
    repeat (2) @(negedge clk);
    chk("R8 write after base write lands in new window", memval(32'h601), 32'hC2C2_0002);
    chk("R8 old window not written", memval(32'h401), 32'h0);

    repeat (4) @(negedge clk);
    chk("R9 one strobe per read", rv_cnt, rd_cnt);
    summary();
  end
endmodule